// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point ALU with Range Tracking

This block is the arithmetic unit of a small 16-bit fixed-point signal processor. It holds two accumulators, A and B, each with its own six-bit flag set. Each cycle the unit can apply one operation to the selected accumulator and a 16-bit right-hand operand. It writes the result back and updates that accumulator's flags.

Besides the usual sign, zero, carry and per-operation overflow, each accumulator keeps a sticky out-of-range flag and a latched sign. With these two flags, a chain of up to three additions or subtractions can report whether the accumulator has left the signed 16-bit range. A first overflow marks it out of range. A later overflow in the opposite direction brings it back. The unit also drives a saturation constant derived from accumulator A's latched sign. Software uses this constant to clamp a result after such a chain.

An accumulator can also be written directly through a load port. A load never touches flags.

Top module: `dsp_alu_ovf`

## Requirements
- R1: After reset both accumulators read 0x0000 and both flag words read 0.
- R2: Arithmetic codes (op_i): 4 SUB, 5 ADD, 6 SBB, 7 ADC, 8 DEC, 9 INC. Each writes the sum or difference modulo 2^16. For 5, 7 and 9, C (flag bit 2) is the carry out. For 4, 6 and 8, C is the borrow.
- R3: Every executed operation sets S0 (bit 0) to result bit 15 and Z (bit 1) to result==0. For arithmetic codes, OV0 (bit 3) is 1 exactly when the signed true result lies outside -32768..32767.
- R4: On an arithmetic code, S1 (bit 4) takes the new S0 only if OV1 was 0 before the operation. Otherwise S1 keeps its value.
- R5: On an arithmetic code, the new OV1 (bit 5) is set from the old OV1 and the new OV0 as follows. Old 0 with OV0 0 gives 0. Old 0 with OV0 1 gives 1. Old 1 with OV0 0 gives 1. Old 1 with OV0 1 gives (S0 == S1).
- R6: The non-arithmetic codes are 1 OR, 2 AND, 3 XOR, 10 ones' complement, 11 arithmetic right shift by 1, 12 left shift by 1, 13 left shift by 2, 14 left shift by 4, and 15 byte swap. Each of them clears OV0 and OV1 and keeps S1. The right shift by 1 sets C to the old bit 0 and the left shift by 1 sets C to the old bit 15. All other codes in this group clear C.
- R7: Code 0 (NOP) changes neither accumulator nor any flag.
- R8: ADC and SBB on one accumulator use the C flag of the other accumulator as their carry or borrow in.
- R9: sat_o is 0x8000 minus accumulator A's S1, giving 0x7FFF or 0x8000. Accumulator B's S1 has no effect on it.
- R10: A load writes ld_data_i into the accumulator chosen by ld_sel_i and leaves all flags unchanged. In a load cycle, op_i is ignored.
- R11: An operation changes only the accumulator selected by sel_i (0 = A, 1 = B) and that accumulator's flags.
- R12: Starting from OV1=0, after up to three chained additions OV1 is 1 exactly when the true sum is outside the signed 16-bit range. A fourth overflow in the opposite direction can clear it falsely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| sel_i | input | 1 | Accumulator the operation targets (0 = A, 1 = B) |
| opnd_i | input | 16 | Right-hand operand |
| ld_i | input | 1 | Direct load strobe |
| ld_sel_i | input | 1 | Accumulator the load targets |
| ld_data_i | input | 16 | Load value |
| acc_a_o | output | 16 | Accumulator A |
| acc_b_o | output | 16 | Accumulator B |
| flg_a_o | output | 6 | Flags of A: {OV1,S1,OV0,C,Z,S0} |
| flg_b_o | output | 6 | Flags of B: {OV1,S1,OV0,C,Z,S0} |
| sat_o | output | 16 | Saturation constant from A's S1 |

## Verification
The properties assume that op_i, sel_i, ld_i and ld_sel_i are driven to known values in every cycle after reset. They also assume that a load cycle carries its own target select, so the suppressed operation never reaches the flags. The stimulus changes inputs only on the falling clock edge and returns op_i to NOP between operations. Each accumulator is preloaded through the load port, and the range-tracking chains begin with an AND against 0xFFFF. That AND clears OV1 first, so the three-addition guarantee applies to every swept chain.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_OR   = 4'h1, OP_AND  = 4'h2, OP_XOR  = 4'h3,
    OP_SUB  = 4'h4, OP_ADD  = 4'h5, OP_SBB  = 4'h6, OP_ADC  = 4'h7,
    OP_DEC  = 4'h8, OP_INC  = 4'h9, OP_NOT  = 4'hA, OP_SHR1 = 4'hB,
    OP_SHL1 = 4'hC, OP_SHL2 = 4'hD, OP_SHL4 = 4'hE, OP_SWAP = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic ov1;
    logic s1;
    logic ov0;
    logic c;
    logic z;
    logic s0;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import dsp_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           c_o,
  output logic           ov0_o,
  output logic           arith_o
);
  localparam int H = W / 2;

  logic [W-1:0] addend;
  logic         cy;
  logic         is_sub;
  logic [W:0]   sum;

  // every add/sub form is folded onto one adder
  always_comb begin
    addend  = opnd_i;
    cy      = 1'b0;
    is_sub  = 1'b0;
    arith_o = 1'b1;
    unique case (op_i)
      OP_ADD: ;
      OP_SUB: begin addend = ~opnd_i; cy = 1'b1;   is_sub = 1'b1; end
      OP_ADC: cy = cin_i;
      OP_SBB: begin addend = ~opnd_i; cy = ~cin_i; is_sub = 1'b1; end
      OP_INC: addend = W'(1);
      OP_DEC: begin addend = '1; is_sub = 1'b1; end
      default: arith_o = 1'b0;
    endcase
  end

  assign sum = {1'b0, acc_i} + {1'b0, addend} + {{W{1'b0}}, cy};

  always_comb begin
    res_o = sum[W-1:0];
    c_o   = sum[W] ^ is_sub;
    ov0_o = (acc_i[W-1] ^ sum[W-1]) & (addend[W-1] ^ sum[W-1]);
    if (!arith_o) begin
      ov0_o = 1'b0;
      c_o   = 1'b0;
      unique case (op_i)
        OP_OR:   res_o = acc_i | opnd_i;
        OP_AND:  res_o = acc_i & opnd_i;
        OP_XOR:  res_o = acc_i ^ opnd_i;
        OP_NOT:  res_o = ~acc_i;
        OP_SHR1: begin res_o = {acc_i[W-1], acc_i[W-1:1]}; c_o = acc_i[0]; end
        OP_SHL1: begin res_o = {acc_i[W-2:0], 1'b0}; c_o = acc_i[W-1]; end
        OP_SHL2: res_o = {acc_i[W-3:0], 2'b00};
        OP_SHL4: res_o = {acc_i[W-5:0], 4'h0};
        OP_SWAP: res_o = {acc_i[H-1:0], acc_i[W-1:H]};
        default: res_o = acc_i;
      endcase
    end
  end
endmodule

// File: rtl/ovf_track.sv
module ovf_track (
  input  logic arith_i,
  input  logic ov0_i,
  input  logic s0_i,
  input  logic s1_q_i,
  input  logic ov1_q_i,
  output logic s1_d_o,
  output logic ov1_d_o
);
  // decisions use the OV1 held before this operation
  always_comb begin
    if (!arith_i) begin
      s1_d_o  = s1_q_i;
      ov1_d_o = 1'b0;
    end else if (!ov1_q_i) begin
      s1_d_o  = s0_i;
      ov1_d_o = ov0_i;
    end else begin
      s1_d_o  = s1_q_i;
      ov1_d_o = ov0_i ? (s0_i == s1_q_i) : 1'b1;
    end
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg
  import dsp_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         acc_we_i,
  input  logic [W-1:0] acc_d_i,
  input  logic         flg_we_i,
  input  alu_flags_t   flg_d_i,
  output logic [W-1:0] acc_q_o,
  output alu_flags_t   flg_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q_o <= '0;
      flg_q_o <= '0;
    end else begin
      if (acc_we_i) acc_q_o <= acc_d_i;
      if (flg_we_i) flg_q_o <= flg_d_i;
    end
  end
endmodule

// File: rtl/dsp_alu_ovf.sv
module dsp_alu_ovf
  import dsp_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic              sel_i,
  input  logic [W-1:0]      opnd_i,
  input  logic              ld_i,
  input  logic              ld_sel_i,
  input  logic [W-1:0]      ld_data_i,
  output logic [W-1:0]      acc_a_o,
  output logic [W-1:0]      acc_b_o,
  output logic [FLAG_W-1:0] flg_a_o,
  output logic [FLAG_W-1:0] flg_b_o,
  output logic [W-1:0]      sat_o
);
  localparam int NACC = 2;

  alu_op_e    op;
  logic [W-1:0] acc_q [NACC];
  alu_flags_t   flg_q [NACC];

  logic [W-1:0] res;
  logic         c_new, ov0_new, arith;
  logic         s1_new, ov1_new;
  logic         exec;
  alu_flags_t   flg_new;

  assign op   = alu_op_e'(op_i);
  assign exec = !ld_i && (op != OP_NOP);

  alu_datapath #(.W(W)) u_dp (
    .op_i    (op),
    .acc_i   (acc_q[sel_i]),
    .opnd_i  (opnd_i),
    .cin_i   (flg_q[~sel_i].c),
    .res_o   (res),
    .c_o     (c_new),
    .ov0_o   (ov0_new),
    .arith_o (arith)
  );

  ovf_track u_ovf (
    .arith_i (arith),
    .ov0_i   (ov0_new),
    .s0_i    (res[W-1]),
    .s1_q_i  (flg_q[sel_i].s1),
    .ov1_q_i (flg_q[sel_i].ov1),
    .s1_d_o  (s1_new),
    .ov1_d_o (ov1_new)
  );

  assign flg_new = '{ov1: ov1_new, s1: s1_new, ov0: ov0_new, c: c_new,
                     z: (res == '0), s0: res[W-1]};

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic ld_hit, op_hit;
    assign ld_hit = ld_i && (ld_sel_i == 1'(i));
    assign op_hit = exec && (sel_i == 1'(i));
    acc_reg #(.W(W)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_we_i (ld_hit || op_hit),
      .acc_d_i  (ld_i ? ld_data_i : res),
      .flg_we_i (op_hit),
      .flg_d_i  (flg_new),
      .acc_q_o  (acc_q[i]),
      .flg_q_o  (flg_q[i])
    );
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign flg_a_o = flg_q[0];
  assign flg_b_o = flg_q[1];
  assign sat_o   = {1'b1, {(W-1){1'b0}}} - {{(W-1){1'b0}}, flg_q[0].s1};

  logic op_arith, op_logic;
  assign op_arith = op inside {OP_ADD, OP_SUB, OP_ADC, OP_SBB, OP_INC, OP_DEC};
  assign op_logic = !op_arith && (op != OP_NOP);

  a_r7_nop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && op == OP_NOP) |=> $stable(acc_a_o) && $stable(acc_b_o)
                                && $stable(flg_a_o) && $stable(flg_b_o));

  a_r10_load_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> $stable(flg_a_o) && $stable(flg_b_o));

  a_r11_b_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !sel_i) |=> $stable(acc_b_o) && $stable(flg_b_o));

  a_r11_a_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && sel_i) |=> $stable(acc_a_o) && $stable(flg_a_o));

  a_r6_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !sel_i && op_logic) |=> !flg_a_o[5] && !flg_a_o[3] && $stable(flg_a_o[4]));

  a_r4_s1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !sel_i && op_arith && flg_a_o[5]) |=> $stable(flg_a_o[4]));

  a_r5_first_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !sel_i && op_arith && !flg_a_o[5]) |=> (flg_a_o[5] == flg_a_o[3]));

  a_r9_sat_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flg_a_o[4]) |-> !sat_o[W-1]);
endmodule

// File: tb/sim_dsp_alu_ovf.sv
module sim_dsp_alu_ovf;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  op;
  logic        sel, ld, ld_sel;
  logic [15:0] opnd, ld_data;
  logic [15:0] acc_a, acc_b, sat;
  logic [5:0]  flg_a, flg_b;

  dsp_alu_ovf u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .sel_i(sel), .opnd_i(opnd),
    .ld_i(ld), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .flg_a_o(flg_a), .flg_b_o(flg_b),
    .sat_o(sat)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_acc [2];
  logic [5:0]  m_flg [2];
  logic [15:0] vals [8] = '{16'h8000, 16'hC000, 16'hFFFF, 16'h0000,
                            16'h0001, 16'h3FFF, 16'h4000, 16'h7FFF};

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk(tag, "acc_a", acc_a, m_acc[0]);
    chk(tag, "acc_b", acc_b, m_acc[1]);
    chk(tag, "flg_a", {10'd0, flg_a}, {10'd0, m_flg[0]});
    chk(tag, "flg_b", {10'd0, flg_b}, {10'd0, m_flg[1]});
    chk(tag, "sat", sat, m_flg[0][4] ? 16'h7FFF : 16'h8000);
  endtask

  function automatic int sx(logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic bit in_rng(int v);
    return (v >= -32768) && (v <= 32767);
  endfunction

  task automatic model_op(int s, logic [3:0] o, logic [15:0] r);
    logic [15:0] lv, res;
    int l, ls, rs, ci, t, ts;
    bit ar, c, ov0, s0, s1, ov1;
    logic [5:0] old;
    lv = m_acc[s]; l = int'(lv); ls = sx(lv); rs = sx(r);
    ci = int'(m_flg[1-s][2]); old = m_flg[s];
    ar = 1; c = 0; ov0 = 0; t = 0; ts = 0; res = lv;
    case (o)
      4'd5: begin t = l + int'(r); ts = ls + rs; c = t > 65535; end
      4'd4: begin t = l - int'(r); ts = ls - rs; c = l < int'(r); end
      4'd7: begin t = l + int'(r) + ci; ts = ls + rs + ci; c = t > 65535; end
      4'd6: begin t = l - int'(r) - ci; ts = ls - rs - ci; c = l < int'(r) + ci; end
      4'd9: begin t = l + 1; ts = ls + 1; c = t > 65535; end
      4'd8: begin t = l - 1; ts = ls - 1; c = l < 1; end
      default: ar = 0;
    endcase
    if (o == 4'd0) return;
    if (ar) begin
      res = t[15:0];
      ov0 = !in_rng(ts);
    end else begin
      case (o)
        4'd1:  res = lv | r;
        4'd2:  res = lv & r;
        4'd3:  res = lv ^ r;
        4'd10: res = ~lv;
        4'd11: begin res = {lv[15], lv[15:1]}; c = lv[0]; end
        4'd12: begin res = {lv[14:0], 1'b0}; c = lv[15]; end
        4'd13: res = lv << 2;
        4'd14: res = lv << 4;
        default: res = {lv[7:0], lv[15:8]};
      endcase
    end
    s0 = res[15];
    if (ar) begin
      s1 = old[5] ? old[4] : s0;
      case ({old[5], ov0})
        2'b00: ov1 = 0;
        2'b01: ov1 = 1;
        2'b10: ov1 = 1;
        default: ov1 = (s0 == old[4]);
      endcase
    end else begin
      s1 = old[4]; ov1 = 0;
    end
    m_flg[s] = {ov1, s1, ov0, c, (res == 16'h0), s0};
    m_acc[s] = res;
  endtask

  task automatic do_op(int s, logic [3:0] o, logic [15:0] r);
    sel = 1'(s); op = o; opnd = r; ld = 0;
    model_op(s, o, r);
    @(negedge clk);
    op = 4'd0;
  endtask

  task automatic do_ld(int s, logic [15:0] d, logic [3:0] o_ignored);
    ld = 1; ld_sel = 1'(s); ld_data = d; op = o_ignored; sel = 1'(s); opnd = 16'h0001;
    m_acc[s] = d;
    @(negedge clk);
    ld = 0; op = 4'd0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; op = 0; sel = 0; opnd = 0; ld = 0; ld_sel = 0; ld_data = 0;
    m_acc[0] = 0; m_acc[1] = 0; m_flg[0] = 0; m_flg[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // sweep every code on both accumulators
    for (int o = 0; o < 16; o++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            do_ld(s, vals[i], 4'd0);
            check_state("R10");
            do_op(s, 4'(o), vals[j]);
            if (o == 0) check_state("R7");
            else if (o >= 4 && o <= 9) begin
              check_state("R2");
              chk("R3", "ov0", {15'd0, (s == 0) ? flg_a[3] : flg_b[3]}, {15'd0, m_flg[s][3]});
            end else check_state("R6");
            if (s == 1) check_state("R11");
          end

    // S1 latch and OV1 cancel, literal expectations
    do_ld(0, 16'h7FFF, 4'd0);
    do_op(0, 4'd2, 16'hFFFF);
    do_op(0, 4'd5, 16'h0001);
    chk("R4", "s1 after first overflow", {15'd0, flg_a[4]}, 16'd1);
    chk("R5", "ov1 after first overflow", {15'd0, flg_a[5]}, 16'd1);
    do_op(0, 4'd5, 16'h8000);
    chk("R4", "s1 held", {15'd0, flg_a[4]}, 16'd1);
    chk("R5", "ov1 cancelled", {15'd0, flg_a[5]}, 16'd0);
    chk("R9", "sat from A", sat, 16'h7FFF);
    do_ld(1, 16'h0001, 4'd0);
    do_op(1, 4'd2, 16'hFFFF);
    do_op(1, 4'd5, 16'h0001);
    chk("R9", "B s1 ignored", sat, 16'h7FFF);
    do_op(0, 4'd2, 16'hFFFF);
    do_op(0, 4'd5, 16'h0001);
    chk("R9", "sat positive s1", sat, 16'h8000);
    check_state("R4");

    // cross carry
    do_ld(1, 16'hFFFF, 4'd0);
    do_op(1, 4'd2, 16'hFFFF);
    do_op(1, 4'd5, 16'h0001);
    do_ld(0, 16'h0005, 4'd0);
    do_op(0, 4'd7, 16'h0010);
    chk("R8", "adc uses B carry", acc_a, 16'h0016);
    do_op(1, 4'd2, 16'hFFFF);
    do_op(0, 4'd6, 16'h0001);
    chk("R8", "sbb uses B borrow", acc_a, 16'h0015);
    do_op(0, 4'd4, 16'h0016);
    do_ld(1, 16'h0002, 4'd0);
    do_op(1, 4'd7, 16'h0003);
    chk("R8", "adc on B uses A carry", acc_b, 16'h0006);
    check_state("R8");

    // load beats a coincident operation
    do_ld(0, 16'h1234, 4'd5);
    chk("R10", "load wins", acc_a, 16'h1234);
    check_state("R10");

    // three-addition range sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++)
          for (int d = 0; d < 8; d++) begin
            do_ld(0, vals[a], 4'd0);
            do_op(0, 4'd2, 16'hFFFF);
            do_op(0, 4'd5, vals[b]);
            do_op(0, 4'd5, vals[c]);
            do_op(0, 4'd5, vals[d]);
            chk("R12", "ov1 vs true sum", {15'd0, flg_a[5]},
                {15'd0, !in_rng(sx(vals[a]) + sx(vals[b]) + sx(vals[c]) + sx(vals[d]))});
            chk("R5", "flags vs model", {10'd0, flg_a}, {10'd0, m_flg[0]});
          end

    // fourth overflow falsely clears
    do_ld(0, 16'h7FFF, 4'd0);
    do_op(0, 4'd2, 16'hFFFF);
    do_op(0, 4'd5, 16'h7FFF);
    do_op(0, 4'd5, 16'h7FFF);
    do_op(0, 4'd5, 16'h7FFF);
    chk("R12", "three same-way adds", {15'd0, flg_a[5]}, 16'd1);
    do_op(0, 4'd5, 16'h8000);
    chk("R12", "fourth add clears", {15'd0, flg_a[5]}, 16'd0);
    chk("R12", "fourth add result", acc_a, 16'h7FFC);

    done = 1;
    summary();
    $finish;
  end
endmodule